// File: doc/BRIEF.md
# Double-Trap Flag and Critical-Error Controller

This block holds the three double-trap flag bits of a hart: the machine-level flag, the supervisor-level flag, and the copy of the supervisor flag kept for a virtualized guest supervisor. The platform's trap logic sets these flags through set strobes when a trap is taken. When a trap-return instruction retires, the block clears the flags that the return unwinds. Which flags are cleared depends on the return type, the privilege and virtualization state the return executes in, and the state it returns to.

The block also resolves an unexpected (double) trap. If a resumable non-maskable interrupt handler is configured and the NMI-enable bit is 1, the block diverts the event to that handler with a one-cycle pulse. That pulse also tells the trap logic not to write the trap-value registers. Otherwise the block enters a sticky critical-error state. In that state it halts execution, masks every interrupt source including NMIs, raises a critical-error line to the platform and freezes its architectural flag state. Only reset leaves this state.

All outputs are registered and change one clock edge after the input that causes the change.

Top module: `dtrap_ctrl`

## Requirements
- R1: A synchronous active-high reset clears `mdt`, `sdt`, `vsdt`, `halt`, `irq_mask`, `crit_err` and `rnmi_divert`.
- R2: A return with `ret_is_s`=0 (machine return), or a return with `ret_is_s`=1 while `cur_priv`=2'b11, clears `mdt` at the next edge. Privilege codes are 2'b00 user, 2'b01 supervisor and 2'b11 machine.
- R3: Such a machine-context return also clears `sdt` when the target is user mode (`tgt_priv`=2'b00 with either `tgt_virt` value) or any mode with `tgt_virt`=1.
- R4: Such a machine-context return also clears `vsdt` when the target is `tgt_priv`=2'b00 with `tgt_virt`=1.
- R5: A supervisor return (`ret_is_s`=1) executed with `cur_priv`=2'b01 and `cur_virt`=0 clears `sdt`. It also clears `vsdt` when the target is `tgt_priv`=2'b00 with `tgt_virt`=1. It leaves `mdt` unchanged.
- R6: A supervisor return executed with `cur_priv`=2'b01 and `cur_virt`=1 clears only `vsdt`.
- R7: A set strobe (`set_mdt`, `set_sdt`, `set_vsdt`) sets its flag at the next edge. When a set and a return-clear hit the same flag in the same cycle, the flag ends up set.
- R8: A `dbl_trap` pulse raises `crit_err`, `halt` and `irq_mask` at the next edge when `HAS_RNMI`=0 or `nmi_en`=0. These three outputs then stay high until reset.
- R9: In the cycle a critical error is entered, and in every cycle after it, set strobes and returns leave all three flags unchanged.
- R10: With `HAS_RNMI`=1 and `nmi_en`=1, a `dbl_trap` pulse raises `rnmi_divert` for exactly one cycle at the next edge. It does not enter the critical-error state and leaves the flags unchanged.
- R11: A supervisor return executed with `cur_priv`=2'b00 clears no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ret_vld | input | 1 | A trap-return instruction retires this cycle |
| ret_is_s | input | 1 | Return type: 0 machine return, 1 supervisor return |
| cur_priv | input | 2 | Privilege the return executes in |
| cur_virt | input | 1 | Virtualization state the return executes in |
| tgt_priv | input | 2 | Privilege the return goes to |
| tgt_virt | input | 1 | Virtualization state the return goes to |
| set_mdt | input | 1 | Set the machine double-trap flag |
| set_sdt | input | 1 | Set the supervisor double-trap flag |
| set_vsdt | input | 1 | Set the guest supervisor double-trap flag |
| dbl_trap | input | 1 | Unexpected trap event |
| nmi_en | input | 1 | NMI-enable bit |
| mdt | output | 1 | Machine double-trap flag |
| sdt | output | 1 | Supervisor double-trap flag |
| vsdt | output | 1 | Guest supervisor double-trap flag |
| halt | output | 1 | Execution stopped |
| irq_mask | output | 1 | All interrupt sources, NMIs included, masked |
| crit_err | output | 1 | Critical-error signal to the platform |
| rnmi_divert | output | 1 | Event diverted to the NMI handler; trap-value registers are not written |

## Verification
Every flag and the error state are single registers that drive the ports directly. A wrong clear decode therefore shows as a wrong flag value one edge after the offending return, and the bench checks this for every combination of return type, source state and target state. A critical-error register that drops or never rises shows on `crit_err`, `halt` and `irq_mask` one edge after the double trap or in any later cycle. A freeze that fails to hold shows as a flag that moves after a set or return issued while in the error state.

// File: rtl/dtrap_pkg.sv
package dtrap_pkg;
  typedef enum logic [1:0] {
    PRIV_U = 2'b00,
    PRIV_S = 2'b01,
    PRIV_M = 2'b11
  } priv_e;

  localparam int NUM_FLAGS = 3;
  localparam int IDX_MDT   = 0;
  localparam int IDX_SDT   = 1;
  localparam int IDX_VSDT  = 2;
endpackage

// File: rtl/dtrap_ret_decode.sv
module dtrap_ret_decode
  import dtrap_pkg::*;
#(
  parameter int PRIV_W = 2
) (
  input  logic                 ret_vld,
  input  logic                 ret_is_s,
  input  logic [PRIV_W-1:0]    cur_priv,
  input  logic                 cur_virt,
  input  logic [PRIV_W-1:0]    tgt_priv,
  input  logic                 tgt_virt,
  output logic [NUM_FLAGS-1:0] clr
);
  logic m_ctx, hs_sret, vs_sret, to_user, to_vu;

  always_comb begin
    // Either return type executed from machine mode unwinds the machine level.
    m_ctx   = ret_vld && (!ret_is_s || cur_priv == PRIV_M);
    hs_sret = ret_vld && ret_is_s && cur_priv == PRIV_S && !cur_virt;
    vs_sret = ret_vld && ret_is_s && cur_priv == PRIV_S && cur_virt;
    to_user = tgt_priv == PRIV_U;
    to_vu   = to_user && tgt_virt;

    clr            = '0;
    clr[IDX_MDT]   = m_ctx;
    clr[IDX_SDT]   = (m_ctx && (to_user || tgt_virt)) || hs_sret;
    clr[IDX_VSDT]  = ((m_ctx || hs_sret) && to_vu) || vs_sret;
  end
endmodule

// File: rtl/dtrap_crit_ctrl.sv
module dtrap_crit_ctrl #(
  parameter bit HAS_RNMI = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic dbl_trap,
  input  logic nmi_en,
  output logic crit_q,
  output logic divert_q,
  output logic freeze
);
  localparam logic RNMI_L = HAS_RNMI;

  logic rnmi_ok, enter;

  always_comb begin
    rnmi_ok = RNMI_L & nmi_en;
    enter   = dbl_trap & ~rnmi_ok & ~crit_q;
    // Architectural state is held from the entering cycle onward.
    freeze  = crit_q | (dbl_trap & ~rnmi_ok);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      crit_q   <= 1'b0;
      divert_q <= 1'b0;
    end else begin
      if (enter) crit_q <= 1'b1;
      divert_q <= dbl_trap & rnmi_ok & ~crit_q;
    end
  end
endmodule

// File: rtl/dtrap_flag_bank.sv
module dtrap_flag_bank #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         freeze,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)          q[i] <= 1'b0;
      else if (!freeze) q[i] <= set[i] | (q[i] & ~clr[i]);
    end
  end
endmodule

// File: rtl/dtrap_ctrl.sv
module dtrap_ctrl
  import dtrap_pkg::*;
#(
  parameter bit HAS_RNMI = 1'b1,
  parameter int PRIV_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ret_vld,
  input  logic              ret_is_s,
  input  logic [PRIV_W-1:0] cur_priv,
  input  logic              cur_virt,
  input  logic [PRIV_W-1:0] tgt_priv,
  input  logic              tgt_virt,
  input  logic              set_mdt,
  input  logic              set_sdt,
  input  logic              set_vsdt,
  input  logic              dbl_trap,
  input  logic              nmi_en,
  output logic              mdt,
  output logic              sdt,
  output logic              vsdt,
  output logic              halt,
  output logic              irq_mask,
  output logic              crit_err,
  output logic              rnmi_divert
);
  logic [NUM_FLAGS-1:0] clr_v, set_v, flag_q;
  logic                 crit_q, freeze;

  dtrap_ret_decode #(.PRIV_W(PRIV_W)) u_dec (
    .ret_vld (ret_vld),
    .ret_is_s(ret_is_s),
    .cur_priv(cur_priv),
    .cur_virt(cur_virt),
    .tgt_priv(tgt_priv),
    .tgt_virt(tgt_virt),
    .clr     (clr_v)
  );

  dtrap_crit_ctrl #(.HAS_RNMI(HAS_RNMI)) u_crit (
    .clk     (clk),
    .rst     (rst),
    .dbl_trap(dbl_trap),
    .nmi_en  (nmi_en),
    .crit_q  (crit_q),
    .divert_q(rnmi_divert),
    .freeze  (freeze)
  );

  always_comb begin
    set_v           = '0;
    set_v[IDX_MDT]  = set_mdt;
    set_v[IDX_SDT]  = set_sdt;
    set_v[IDX_VSDT] = set_vsdt;
  end

  dtrap_flag_bank #(.N(NUM_FLAGS)) u_flags (
    .clk   (clk),
    .rst   (rst),
    .freeze(freeze),
    .set   (set_v),
    .clr   (clr_v),
    .q     (flag_q)
  );

  assign mdt      = flag_q[IDX_MDT];
  assign sdt      = flag_q[IDX_SDT];
  assign vsdt     = flag_q[IDX_VSDT];
  assign crit_err = crit_q;
  assign halt     = crit_q;
  assign irq_mask = crit_q;
endmodule

// File: rtl/dtrap_ctrl_chk.sv
module dtrap_ctrl_chk #(
  parameter bit HAS_RNMI = 1'b1,
  parameter int PRIV_W   = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              ret_vld,
  input logic              ret_is_s,
  input logic [PRIV_W-1:0] cur_priv,
  input logic              cur_virt,
  input logic              set_mdt,
  input logic              set_sdt,
  input logic              set_vsdt,
  input logic              dbl_trap,
  input logic              nmi_en,
  input logic              mdt,
  input logic              sdt,
  input logic              vsdt,
  input logic              halt,
  input logic              irq_mask,
  input logic              crit_err,
  input logic              rnmi_divert
);
  localparam logic RNMI_L = HAS_RNMI;

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> !mdt && !sdt && !vsdt && !crit_err && !halt && !irq_mask && !rnmi_divert);

  a_r2_mctx_clears_mdt: assert property (@(posedge clk) disable iff (rst)
    (ret_vld && (!ret_is_s || cur_priv == 2'b11) && !set_mdt && !crit_err && !dbl_trap)
      |=> !mdt);

  a_r6_vs_sret_keeps_upper: assert property (@(posedge clk) disable iff (rst)
    (ret_vld && ret_is_s && cur_priv == 2'b01 && cur_virt && !set_mdt && !set_sdt && !dbl_trap)
      |=> $stable(mdt) && $stable(sdt));

  a_r7_set_wins: assert property (@(posedge clk) disable iff (rst)
    (set_mdt && !crit_err && !dbl_trap) |=> mdt);

  a_r8_enter_crit: assert property (@(posedge clk) disable iff (rst)
    (dbl_trap && !(RNMI_L && nmi_en)) |=> crit_err && halt && irq_mask);

  a_r8_crit_sticky: assert property (@(posedge clk) disable iff (rst)
    crit_err |=> crit_err);

  a_r9_flags_frozen: assert property (@(posedge clk) disable iff (rst)
    crit_err |=> $stable(mdt) && $stable(sdt) && $stable(vsdt));

  a_r10_divert: assert property (@(posedge clk) disable iff (rst)
    (dbl_trap && RNMI_L && nmi_en && !crit_err) |=> rnmi_divert && !crit_err);

  a_r10_divert_excl: assert property (@(posedge clk) disable iff (rst)
    rnmi_divert |-> !crit_err);
endmodule

bind dtrap_ctrl dtrap_ctrl_chk #(.HAS_RNMI(HAS_RNMI), .PRIV_W(PRIV_W)) u_chk (.*);

// File: tb/dtrap_ctrl_tb.sv
module dtrap_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ret_vld = 0, ret_is_s = 0, cur_virt = 0, tgt_virt = 0;
  logic [1:0] cur_priv = 2'b11, tgt_priv = 2'b00;
  logic set_mdt = 0, set_sdt = 0, set_vsdt = 0, dbl_trap = 0, nmi_en = 1;
  logic mdt, sdt, vsdt, halt, irq_mask, crit_err, rnmi_divert;
  logic mdt_n, sdt_n, vsdt_n, halt_n, irq_n, crit_n, div_n;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dtrap_ctrl #(.HAS_RNMI(1'b1)) u_dut (
    .clk, .rst, .ret_vld, .ret_is_s, .cur_priv, .cur_virt, .tgt_priv, .tgt_virt,
    .set_mdt, .set_sdt, .set_vsdt, .dbl_trap, .nmi_en,
    .mdt, .sdt, .vsdt, .halt, .irq_mask, .crit_err, .rnmi_divert
  );

  dtrap_ctrl #(.HAS_RNMI(1'b0)) u_dut_nr (
    .clk, .rst, .ret_vld, .ret_is_s, .cur_priv, .cur_virt, .tgt_priv, .tgt_virt,
    .set_mdt, .set_sdt, .set_vsdt, .dbl_trap, .nmi_en,
    .mdt(mdt_n), .sdt(sdt_n), .vsdt(vsdt_n), .halt(halt_n), .irq_mask(irq_n),
    .crit_err(crit_n), .rnmi_divert(div_n)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    ret_vld = 0; set_mdt = 0; set_sdt = 0; set_vsdt = 0; dbl_trap = 0;
  endtask

  // Drive at a falling edge, let one rising edge pass, sample at the next falling edge.
  task automatic step();
    @(negedge clk);
  endtask

  // Flags a return clears, derived from the requirement text. Bit 0 mdt, 1 sdt, 2 vsdt.
  function automatic logic [2:0] exp_clr(logic is_s, logic [1:0] cp, logic cv,
                                         logic [1:0] tp, logic tv);
    logic mctx, hs, vs;
    logic [2:0] r;
    mctx = !is_s || cp == 2'b11;
    hs   = is_s && cp == 2'b01 && !cv;
    vs   = is_s && cp == 2'b01 && cv;
    r[0] = mctx;
    r[1] = (mctx && (tp == 2'b00 || tv)) || hs;
    r[2] = ((mctx || hs) && tp == 2'b00 && tv) || vs;
    return r;
  endfunction

  function automatic logic [1:0] priv_of(int i);
    return (i == 2) ? 2'b11 : 2'(i);
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > WD_LIMIT) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WD_LIMIT);
        finish_run();
      end
    end
  end

  initial begin
    idle();
    rst = 1;
    step(); step();
    rst = 0;
    step();
    // R1: state after reset
    chk("R1 flags", {5'b0, vsdt, sdt, mdt}, 8'h0);
    chk("R1 error outputs", {4'b0, rnmi_divert, crit_err, halt, irq_mask}, 8'h0);

    // Sweep every return type, source state and target state.
    for (int s = 0; s < 2; s++)
      for (int ci = 0; ci < 3; ci++)
        for (int cvi = 0; cvi < 2; cvi++)
          for (int ti = 0; ti < 3; ti++)
            for (int tvi = 0; tvi < 2; tvi++) begin
              logic [2:0] e;
              string tag;
              if (ci == 2 && cvi == 1) continue;
              if (ti == 2 && tvi == 1) continue;
              set_mdt = 1; set_sdt = 1; set_vsdt = 1;
              step();
              idle();
              chk("R7 set strobes", {5'b0, vsdt, sdt, mdt}, 8'h7);
              ret_vld = 1; ret_is_s = s[0]; cur_priv = priv_of(ci); cur_virt = cvi[0];
              tgt_priv = priv_of(ti); tgt_virt = tvi[0];
              e = ~exp_clr(s[0], priv_of(ci), cvi[0], priv_of(ti), tvi[0]);
              if (s == 0 || ci == 2) tag = "R2 R3 R4 machine-context return";
              else if (ci == 1 && cvi == 0) tag = "R5 supervisor return";
              else if (ci == 1) tag = "R6 guest supervisor return";
              else tag = "R11 return from user";
              step();
              idle();
              chk(tag, {5'b0, vsdt, sdt, mdt}, {5'b0, e});
            end

    // R7: set wins over a clear in the same cycle
    ret_vld = 1; ret_is_s = 0; cur_priv = 2'b11; cur_virt = 0; tgt_priv = 2'b00; tgt_virt = 1;
    set_mdt = 1; set_vsdt = 1;
    step();
    idle();
    chk("R7 set beats clear", {5'b0, vsdt, sdt, mdt}, 8'h5);

    // R10: diverted double trap with the handler present and enabled
    nmi_en = 1; dbl_trap = 1;
    step();
    idle();
    chk("R10 divert pulse", {6'b0, rnmi_divert, crit_err}, 8'h2);
    chk("R10 flags untouched", {5'b0, vsdt, sdt, mdt}, 8'h5);
    chk("R8 no handler variant enters error", {5'b0, crit_n, halt_n, irq_n}, 8'h7);
    step();
    chk("R10 divert single cycle", {6'b0, rnmi_divert, crit_err}, 8'h0);

    // R8 and R9: error entry with NMI disabled, with a return and a set in the same cycle
    nmi_en = 0; dbl_trap = 1; set_sdt = 1;
    ret_vld = 1; ret_is_s = 0; cur_priv = 2'b11; tgt_priv = 2'b00; tgt_virt = 1;
    step();
    idle();
    chk("R8 error outputs", {5'b0, crit_err, halt, irq_mask}, 8'h7);
    chk("R9 entry cycle frozen", {5'b0, vsdt, sdt, mdt}, 8'h5);
    chk("R10 no divert when disabled", {7'b0, rnmi_divert}, 8'h0);

    // R9: while in error, sets and returns have no effect
    set_sdt = 1;
    step();
    idle();
    chk("R9 set ignored", {5'b0, vsdt, sdt, mdt}, 8'h5);
    ret_vld = 1; ret_is_s = 1; cur_priv = 2'b01; cur_virt = 1;
    step();
    idle();
    chk("R9 return ignored", {5'b0, vsdt, sdt, mdt}, 8'h5);
    nmi_en = 1;
    for (int k = 0; k < 5; k++) step();
    chk("R8 error sticky", {5'b0, crit_err, halt, irq_mask}, 8'h7);

    // R1: reset leaves the error state
    rst = 1;
    step();
    rst = 0;
    chk("R1 reset clears error", {4'b0, rnmi_divert, crit_err, halt, irq_mask}, 8'h0);
    chk("R1 reset clears flags", {5'b0, vsdt, sdt, mdt}, 8'h0);
    chk("R1 reset clears error no-handler", {5'b0, crit_n, halt_n, irq_n}, 8'h0);

    finish_run();
  end
endmodule